// File: doc/BRIEF.md
# Serial Divider-Setting Receiver for a Frequency Synthesizer

This block takes divider settings for a frequency synthesizer from a three-wire serial link: a data line, a serial clock and an enable line. It is SPI compatible. The three lines are sampled by the system clock through two-flop synchronizers. A data bit is captured on each detected low-to-high transition of the serial clock. Bits arrive most significant first, so the newest bit sits at the bottom of the shift register.

When enable rises, the last bit of the word is read as the control bit, and the number of bits received since the previous enable rise is compared against the two legal frame lengths. A 15-bit frame whose control bit is 1 loads the 14-bit reference divider setting. An 18-bit frame whose control bit is 0 loads the 10-bit main count and the 7-bit swallow count together. Any other combination is dropped. Each written latch gives a one-cycle update strobe. The latch that was not selected keeps its value.

Top module: `synth_prog_if`

## Requirements
- R1: After reset, the reference, main and swallow outputs are zero and both update strobes are low.
- R2: If 15 bits arrive and the last one is 1, the reference output takes the first 14 bits on the enable rise, with the first bit received as its most significant bit.
- R3: If 18 bits arrive and the last one is 0, the main output takes the first 10 bits and the swallow output takes the next 7 bits on the enable rise. Both fields are sent most significant bit first.
- R4: A committed frame changes only the latch it selects. The other latch keeps its previous value, and the two strobes are never high together.
- R5: Each accepted frame raises the strobe of the written latch for exactly one system clock cycle. The reference strobe is ref_upd_o, and the single strobe for main plus swallow is fb_upd_o.
- R6: An enable rise after a bit count other than 15 or 18 (including counts above 18) changes no output and raises no strobe.
- R7: A 15-bit frame with a control bit of 0, or an 18-bit frame with a control bit of 1, changes no output and raises no strobe.
- R8: The bit count restarts at every enable rise, whether or not the frame before it was accepted. One bit is taken per rising serial clock edge.
- R9: The outputs hold steady while bits are shifting in. They change only in a cycle where the matching strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the serial lines |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock; one bit is captured per rising edge |
| sdata_i | input | 1 | Serial data, most significant bit first |
| sen_i | input | 1 | Enable; its rising edge commits the frame |
| ref_div_o | output | 14 | Latched reference divider setting |
| main_cnt_o | output | 10 | Latched main count |
| swal_cnt_o | output | 7 | Latched swallow count |
| ref_upd_o | output | 1 | One-cycle strobe when the reference setting is written |
| fb_upd_o | output | 1 | One-cycle strobe when main and swallow counts are written |

## Verification
On every cycle, the assertions check four things:
- Each output holds unless its strobe is high.
- Each strobe lasts a single cycle.
- The two strobes never coincide.
- Each strobe follows an enable rise that saw exactly the frame length for its target.

The bit order of the fields, the choice of latch by the control bit, and the dropping of wrong-length or mismatched frames all depend on what was sent serially. Only the bench scenarios can show these, by comparing the latched values against the words it sent.

// File: rtl/synth_prog_pkg.sv
package synth_prog_pkg;
  typedef enum logic [1:0] {
    ROUTE_NONE,
    ROUTE_REF,
    ROUTE_FB
  } route_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sync_bus.sv
module sync_bus #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg[s] <= '0;
      else if (s == 0) stg[s] <= d_i;
      else stg[s] <= stg[(s == 0) ? 0 : s - 1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/frame_shifter.sv
module frame_shifter #(
  parameter int unsigned SR_W  = 18,
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             shift_i,
  input  logic             bit_i,
  input  logic             clr_i,
  output logic [SR_W-1:0]  sr_o,
  output logic [CNT_W-1:0] cnt_o
);
  // count saturates one past the longest frame so overlong frames never alias
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(SR_W + 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_o  <= '0;
      cnt_o <= '0;
    end else begin
      if (shift_i) sr_o <= {sr_o[SR_W-2:0], bit_i};
      if (clr_i) cnt_o <= '0;
      else if (shift_i && cnt_o != CNT_SAT) cnt_o <= cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/frame_commit.sv
module frame_commit
  import synth_prog_pkg::*;
#(
  parameter int unsigned REF_W  = 14,
  parameter int unsigned MAIN_W = 10,
  parameter int unsigned SWAL_W = 7,
  parameter int unsigned SR_W   = 18,
  parameter int unsigned CNT_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              commit_i,
  input  logic [SR_W-1:0]   sr_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [REF_W-1:0]  ref_o,
  output logic [MAIN_W-1:0] main_o,
  output logic [SWAL_W-1:0] swal_o,
  output logic              ref_upd_o,
  output logic              fb_upd_o
);
  localparam int unsigned REF_LEN = REF_W + 1;
  localparam int unsigned FB_LEN  = MAIN_W + SWAL_W + 1;

  route_e route;

  always_comb begin
    route = ROUTE_NONE;
    if (commit_i) begin
      if (cnt_i == CNT_W'(REF_LEN) && sr_i[0]) route = ROUTE_REF;
      else if (cnt_i == CNT_W'(FB_LEN) && !sr_i[0]) route = ROUTE_FB;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_o     <= '0;
      main_o    <= '0;
      swal_o    <= '0;
      ref_upd_o <= 1'b0;
      fb_upd_o  <= 1'b0;
    end else begin
      ref_upd_o <= (route == ROUTE_REF);
      fb_upd_o  <= (route == ROUTE_FB);
      if (route == ROUTE_REF) ref_o <= sr_i[REF_W:1];
      if (route == ROUTE_FB) begin
        main_o <= sr_i[FB_LEN-1 -: MAIN_W];
        swal_o <= sr_i[SWAL_W:1];
      end
    end
  end
endmodule

// File: rtl/synth_prog_if.sv
module synth_prog_if
  import synth_prog_pkg::*;
#(
  parameter int unsigned REF_W       = 14,
  parameter int unsigned MAIN_W      = 10,
  parameter int unsigned SWAL_W      = 7,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              sdata_i,
  input  logic              sen_i,
  output logic [REF_W-1:0]  ref_div_o,
  output logic [MAIN_W-1:0] main_cnt_o,
  output logic [SWAL_W-1:0] swal_cnt_o,
  output logic              ref_upd_o,
  output logic              fb_upd_o
);
  localparam int unsigned SR_W  = max_u(REF_W + 1, MAIN_W + SWAL_W + 1);
  localparam int unsigned CNT_W = $clog2(SR_W + 2);

  logic [2:0]       pins_s;
  logic             sclk_q, en_q;
  logic             sclk_rise, en_rise;
  logic [SR_W-1:0]  sr;
  logic [CNT_W-1:0] bit_cnt;

  sync_bus #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sen_i, sdata_i, sclk_i}),
    .q_o   (pins_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      sclk_q <= pins_s[0];
      en_q   <= pins_s[2];
    end
  end

  assign sclk_rise = pins_s[0] & ~sclk_q;
  assign en_rise   = pins_s[2] & ~en_q;

  frame_shifter #(.SR_W(SR_W), .CNT_W(CNT_W)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .shift_i(sclk_rise),
    .bit_i  (pins_s[1]),
    .clr_i  (en_rise),
    .sr_o   (sr),
    .cnt_o  (bit_cnt)
  );

  frame_commit #(
    .REF_W (REF_W),
    .MAIN_W(MAIN_W),
    .SWAL_W(SWAL_W),
    .SR_W  (SR_W),
    .CNT_W (CNT_W)
  ) u_commit (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .commit_i (en_rise),
    .sr_i     (sr),
    .cnt_i    (bit_cnt),
    .ref_o    (ref_div_o),
    .main_o   (main_cnt_o),
    .swal_o   (swal_cnt_o),
    .ref_upd_o(ref_upd_o),
    .fb_upd_o (fb_upd_o)
  );
endmodule

// File: rtl/synth_prog_if_chk.sv
module synth_prog_if_chk #(
  parameter int unsigned REF_W  = 14,
  parameter int unsigned MAIN_W = 10,
  parameter int unsigned SWAL_W = 7,
  parameter int unsigned CNT_W  = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_rise,
  input logic [CNT_W-1:0]  bit_cnt,
  input logic [REF_W-1:0]  ref_div_o,
  input logic [MAIN_W-1:0] main_cnt_o,
  input logic [SWAL_W-1:0] swal_cnt_o,
  input logic              ref_upd_o,
  input logic              fb_upd_o
);
  localparam int unsigned REF_LEN = REF_W + 1;
  localparam int unsigned FB_LEN  = MAIN_W + SWAL_W + 1;

  p_ref_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ref_upd_o |-> $stable(ref_div_o));

  p_fb_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fb_upd_o |-> ($stable(main_cnt_o) && $stable(swal_cnt_o)));

  p_ref_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_upd_o |=> !ref_upd_o);

  p_fb_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fb_upd_o |=> !fb_upd_o);

  p_one_target_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ref_upd_o && fb_upd_o));

  p_ref_len_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_upd_o |-> ($past(en_rise) && $past(bit_cnt) == CNT_W'(REF_LEN)));

  p_fb_len_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fb_upd_o |-> ($past(en_rise) && $past(bit_cnt) == CNT_W'(FB_LEN)));
endmodule

bind synth_prog_if synth_prog_if_chk #(
  .REF_W (REF_W),
  .MAIN_W(MAIN_W),
  .SWAL_W(SWAL_W),
  .CNT_W (CNT_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .en_rise   (en_rise),
  .bit_cnt   (bit_cnt),
  .ref_div_o (ref_div_o),
  .main_cnt_o(main_cnt_o),
  .swal_cnt_o(swal_cnt_o),
  .ref_upd_o (ref_upd_o),
  .fb_upd_o  (fb_upd_o)
);

// File: tb/synth_prog_if_tb_top.sv
`timescale 1ns/1ps
module synth_prog_if_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, sdata = 1'b0, sen = 1'b0;
  logic [13:0] ref_div;
  logic [9:0]  main_cnt;
  logic [6:0]  swal_cnt;
  logic        ref_upd, fb_upd;

  int checks = 0, errors = 0;
  int ref_pulses = 0, fb_pulses = 0;
  int exp_ref = 0, exp_main = 0, exp_swal = 0, exp_rp = 0, exp_fp = 0;

  always #4 clk = ~clk;

  synth_prog_if dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .sclk_i    (sclk),
    .sdata_i   (sdata),
    .sen_i     (sen),
    .ref_div_o (ref_div),
    .main_cnt_o(main_cnt),
    .swal_cnt_o(swal_cnt),
    .ref_upd_o (ref_upd),
    .fb_upd_o  (fb_upd)
  );

  always @(posedge clk) begin
    if (ref_upd) ref_pulses <= ref_pulses + 1;
    if (fb_upd) fb_pulses <= fb_pulses + 1;
  end

  task automatic check_eq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    check_eq(req, "ref", int'(ref_div), exp_ref);
    check_eq(req, "main", int'(main_cnt), exp_main);
    check_eq(req, "swal", int'(swal_cnt), exp_swal);
    check_eq(req, "ref strobes", ref_pulses, exp_rp);
    check_eq(req, "fb strobes", fb_pulses, exp_fp);
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(input logic [31:0] word, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      sdata = word[i];
      wait_n(4);
      sclk = 1'b1;
      wait_n(4);
      sclk = 1'b0;
      wait_n(4);
    end
  endtask

  task automatic pulse_en();
    sen = 1'b1;
    wait_n(4);
    sen = 1'b0;
    wait_n(6);
  endtask

  task automatic load_ref(input int v, input string req);
    send_bits({17'd0, v[13:0], 1'b1}, 15);
    pulse_en();
    exp_ref = v;
    exp_rp++;
    check_all(req);
  endtask

  task automatic load_fb(input int m, input int s, input string req);
    send_bits({14'd0, m[9:0], s[6:0], 1'b0}, 18);
    pulse_en();
    exp_main = m;
    exp_swal = s;
    exp_fp++;
    check_all(req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait_n(3);
    check_all("R1");
    check_eq("R1", "ref strobe level", int'(ref_upd), 0);
    check_eq("R1", "fb strobe level", int'(fb_upd), 0);
    rst_n = 1'b1;
    wait_n(3);
    check_all("R1");

    // R2 reference sweep: boundaries, walking ones, alternating bits
    load_ref(16383, "R2");
    load_ref(1, "R2");
    for (int b = 0; b < 14; b++) load_ref(1 << b, "R2");
    load_ref(14'h2AAA, "R2");
    load_ref(14'h1555, "R2");

    // R3 feedback sweep: every swallow value, varied main counts; R4 ref holds
    for (int s = 0; s < 128; s++) load_fb((s * 37 + 5) % 1024, s, "R3");
    load_fb(1023, 127, "R3");
    load_fb(0, 0, "R3");
    load_fb(512, 64, "R4");

    // R4 reference write leaves feedback latches alone
    load_ref(12345, "R4");

    // R6 wrong bit counts are dropped
    foreach (exp_ref[i]) ;
    for (int k = 0; k < 7; k++) begin
      int n;
      n = (k == 0) ? 14 : (k == 1) ? 16 : (k == 2) ? 17 : (k == 3) ? 19 :
          (k == 4) ? 20 : (k == 5) ? 1 : 31;
      send_bits(32'h5555_5555, n);
      pulse_en();
      check_all("R6");
      send_bits(32'hAAAA_AAAA, n);
      pulse_en();
      check_all("R6");
    end

    // R7 length and control bit disagree
    send_bits({17'd0, 14'h0ABC, 1'b0}, 15);
    pulse_en();
    check_all("R7");
    send_bits({14'd0, 10'd300, 7'd9, 1'b1}, 18);
    pulse_en();
    check_all("R7");

    // R8 count restarts at each enable rise
    send_bits(32'h3FF, 10);
    pulse_en();
    check_all("R8");
    load_ref(777, "R8");
    send_bits(32'h7, 3);
    pulse_en();
    load_fb(33, 17, "R8");

    // R9 outputs steady mid-frame before enable
    send_bits({17'd0, 14'd4321, 1'b1}, 15);
    check_all("R9");
    pulse_en();
    exp_ref = 4321;
    exp_rp++;
    check_all("R9");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule